// File: doc/BRIEF.md
# Receive FIFO with Threshold-Driven Interrupt and Flow Control

This block buffers received characters for a single serial channel. Each stored entry holds one 8-bit character and three error marks: parity, framing and line break. The receiver offers a character with a one-cycle push strobe. The host takes the oldest character with a one-cycle pop strobe. The oldest entry is always presented on the head outputs.

A control write sets the operating mode and the fill threshold. The threshold is one of four levels that grow toward the 128-entry depth. When the fill level reaches the threshold, the block raises its data-available condition. When automatic flow control is enabled, the same comparison withdraws the request-to-send permission toward the far end. The block also raises a receive timeout when a few characters sit below the threshold and the line has gone quiet. With FIFO mode off, the block behaves as a one-character holding register.

The status outputs feed the line status logic and the interrupt logic: data ready, sticky overrun, error-in-buffer, threshold reached and timeout.

Top module: `rxfifo_trig`

## Requirements
- R1: `ctl_data[7:6]` selects the threshold on a control write: 00 gives 1, 01 gives 16, 10 gives 64 and 11 gives 112 entries. `trig_hit` is 1 exactly when `level` is at or above the selected threshold.
- R2: Accepted characters leave in arrival order. `head_byte`, `head_perr`, `head_ferr` and `head_brk` show the oldest entry. `level` counts the stored entries and `data_ready` is 1 whenever `level` is non-zero.
- R3: A push into a full buffer with no pop in the same cycle discards the incoming character and keeps the stored contents. It also sets `overrun`, which stays set until an `ovr_clr` pulse.
- R4: A control write with `ctl_data[1]`=1 empties the buffer and its error record in one cycle. A control write that changes the mode bit `ctl_data[0]` also empties the buffer.
- R5: While `afc_en` is 1, `rts_ok` is 0 when the threshold is reached and returns to 1 as soon as `level` falls below it. While `afc_en` is 0, `rts_ok` is always 1.
- R6: With the mode bit `ctl_data[0]`=0, the buffer holds at most one character and the threshold is 1. With the mode bit set to 1, the capacity is 128.
- R7: `fifo_err` is 1 while at least one stored entry carries a parity, framing or break mark.
- R8: In FIFO mode, `timeout` is 1 when all of these hold: data is present, the level is below the threshold, and four `char_tick` pulses have arrived since the last accepted push, pop or empty operation.
- R9: After reset, `level`=0, `data_ready`=0, `overrun`=0, `fifo_err`=0, `timeout`=0 and `rts_ok`=1. The mode starts as single-register with a threshold of 1.
- R10: A pop while the buffer is empty has no effect on `level` or on later contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Receiver offers a character this cycle |
| rx_byte | input | 8 | Offered character |
| rx_perr | input | 1 | Parity error mark of the offered character |
| rx_ferr | input | 1 | Framing error mark of the offered character |
| rx_brk | input | 1 | Break mark of the offered character |
| host_pop | input | 1 | Host removes the head entry |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control value: [7:6] threshold, [1] empty, [0] FIFO mode |
| afc_en | input | 1 | Automatic flow control enable |
| char_tick | input | 1 | One pulse per character time |
| head_byte | output | 8 | Oldest stored character |
| head_perr | output | 1 | Parity mark of the oldest entry |
| head_ferr | output | 1 | Framing mark of the oldest entry |
| head_brk | output | 1 | Break mark of the oldest entry |
| level | output | 8 | Number of stored entries |
| data_ready | output | 1 | At least one entry stored |
| overrun | output | 1 | Sticky overrun flag |
| fifo_err | output | 1 | Some stored entry has an error mark |
| trig_hit | output | 1 | Level at or above threshold |
| timeout | output | 1 | Receive timeout condition |
| rts_ok | output | 1 | Request-to-send permission |

## Verification
The hardest states to reach are the upper thresholds and the full buffer. Reaching them takes up to 128 consecutive accepted pushes after a clean empty operation. The stimulus table therefore empties the buffer, reprograms the threshold and fills it to one entry short of each threshold and then exactly to it. At both points it checks the data-available and flow-control outputs. The overrun case fills all 128 entries and pushes once more. The bench then confirms that the head and the level are unchanged and that the drain still returns the stored characters in order.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [BYTE_W-1:0] data;
  } rxf_entry_t;

  localparam int ENTRY_W = $bits(rxf_entry_t);
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  rxf_entry_t       wr_entry,
  input  logic             rd_req,
  input  logic             clr,
  input  logic             single,
  output rxf_entry_t       head,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             err_any
);
  rxf_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, err_q, err_d;
  logic             empty, wr_has_err, rd_has_err;

  assign empty = (cnt_q == '0);
  assign full  = single ? !empty : (cnt_q == CNT_W'(DEPTH));
  assign rd_ok = rd_req && !empty && !clr;
  assign wr_ok = wr_req && (!full || rd_ok) && !clr;

  assign head       = mem[rptr_q];
  assign wr_has_err = wr_entry.perr | wr_entry.ferr | wr_entry.brk;
  assign rd_has_err = head.perr | head.ferr | head.brk;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    err_d  = err_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
      err_d  = '0;
    end else begin
      if (wr_ok) wptr_d = wptr_q + 1'b1;
      if (rd_ok) rptr_d = rptr_q + 1'b1;
      cnt_d = cnt_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
      err_d = err_q + CNT_W'(wr_ok && wr_has_err) - CNT_W'(rd_ok && rd_has_err);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      err_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wr_entry;
  end

  assign cnt     = cnt_q;
  assign err_any = (err_q != '0);
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int DEPTH    = 128,
  parameter int TRIG_L0  = 1,
  parameter int TRIG_L1  = 16,
  parameter int TRIG_L2  = 64,
  parameter int TRIG_L3  = 112,
  parameter int TO_CHARS = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TO_W  = $clog2(TO_CHARS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             fifo_mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             activity,
  input  logic             char_tick,
  input  logic             afc_en,
  output logic             hit,
  output logic             idle_to,
  output logic             rts_ok
);
  logic [CNT_W-1:0] thresh;
  logic [TO_W-1:0]  quiet_q, quiet_d;
  logic             quiet_en;

  always_comb begin
    unique case (sel)
      2'b00:   thresh = CNT_W'(TRIG_L0);
      2'b01:   thresh = CNT_W'(TRIG_L1);
      2'b10:   thresh = CNT_W'(TRIG_L2);
      default: thresh = CNT_W'(TRIG_L3);
    endcase
    if (!fifo_mode) thresh = CNT_W'(1);
  end

  assign hit    = (cnt >= thresh);
  assign rts_ok = !afc_en || !hit;

  assign quiet_en = activity || (char_tick && (cnt != '0) && (quiet_q != TO_W'(TO_CHARS)));

  always_comb begin
    quiet_d = quiet_q;
    if (activity)      quiet_d = '0;
    else if (quiet_en) quiet_d = quiet_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        quiet_q <= '0;
    else if (quiet_en) quiet_q <= quiet_d;
  end

  assign idle_to = fifo_mode && (cnt != '0) && !hit && (quiet_q == TO_W'(TO_CHARS));
endmodule

// File: rtl/rxfifo_trig.sv
module rxfifo_trig
  import rxf_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int TRIG_L0  = 1,
  parameter int TRIG_L1  = 16,
  parameter int TRIG_L2  = 64,
  parameter int TRIG_L3  = 112,
  parameter int TO_CHARS = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              host_pop,
  input  logic              ovr_clr,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_data,
  input  logic              afc_en,
  input  logic              char_tick,
  output logic [BYTE_W-1:0] head_byte,
  output logic              head_perr,
  output logic              head_ferr,
  output logic              head_brk,
  output logic [CNT_W-1:0]  level,
  output logic              data_ready,
  output logic              overrun,
  output logic              fifo_err,
  output logic              trig_hit,
  output logic              timeout,
  output logic              rts_ok
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic       fifo_mode_q, fifo_mode_d;
  logic [1:0] trig_q, trig_d;
  logic       ovr_q, ovr_d;
  logic       clr, full, wr_ok, rd_ok, ctl_en;
  rxf_entry_t wr_entry, head;

  assign clr    = ctl_wr && (ctl_data[1] || (ctl_data[0] != fifo_mode_q));
  assign ctl_en = ctl_wr;

  always_comb begin
    fifo_mode_d = fifo_mode_q;
    trig_d      = trig_q;
    if (ctl_en) begin
      fifo_mode_d = ctl_data[0];
      trig_d      = ctl_data[7:6];
    end
    ovr_d = ovr_q;
    if (ovr_clr) ovr_d = 1'b0;
    if (rx_push && !wr_ok && !clr) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fifo_mode_q <= 1'b0;
      trig_q      <= 2'b00;
      ovr_q       <= 1'b0;
    end else begin
      if (ctl_en) begin
        fifo_mode_q <= fifo_mode_d;
        trig_q      <= trig_d;
      end
      ovr_q <= ovr_d;
    end
  end

  assign wr_entry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_byte};

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_req   (rx_push),
    .wr_entry (wr_entry),
    .rd_req   (host_pop),
    .clr      (clr),
    .single   (!fifo_mode_q),
    .head     (head),
    .cnt      (level),
    .full     (full),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .err_any  (fifo_err)
  );

  rxf_level #(
    .DEPTH(DEPTH), .TRIG_L0(TRIG_L0), .TRIG_L1(TRIG_L1),
    .TRIG_L2(TRIG_L2), .TRIG_L3(TRIG_L3), .TO_CHARS(TO_CHARS)
  ) u_level (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel       (trig_q),
    .fifo_mode (fifo_mode_q),
    .cnt       (level),
    .activity  (wr_ok || rd_ok || clr),
    .char_tick (char_tick),
    .afc_en    (afc_en),
    .hit       (trig_hit),
    .idle_to   (timeout),
    .rts_ok    (rts_ok)
  );

  assign head_byte  = head.data;
  assign head_perr  = head.perr;
  assign head_ferr  = head.ferr;
  assign head_brk   = head.brk;
  assign data_ready = (level != '0);
  assign overrun    = ovr_q;
endmodule

// File: rtl/rxfifo_trig_chk.sv
module rxfifo_trig_chk #(
  parameter int DEPTH   = 128,
  parameter int TRIG_L3 = 112,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_push,
  input logic             host_pop,
  input logic             ctl_wr,
  input logic             afc_en,
  input logic [CNT_W-1:0] level,
  input logic             data_ready,
  input logic             overrun,
  input logic             fifo_err,
  input logic             trig_hit,
  input logic             timeout,
  input logic             rts_ok,
  input logic             fifo_mode_q
);
  assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= CNT_W'(DEPTH)) && (fifo_mode_q || level <= CNT_W'(1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !host_pop && !ctl_wr &&
     level == (fifo_mode_q ? CNT_W'(DEPTH) : CNT_W'(1)))
    |=> ($stable(level) && overrun));

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && !rx_push && !ctl_wr && level == '0) |=> (level == '0));

  assert_rts_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_en && level >= CNT_W'(TRIG_L3)) |-> !rts_ok);

  assert_rts_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> rts_ok);

  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (data_ready && !trig_hit));

  assert_err_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> !fifo_err);

  assert_hit_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_ready);
endmodule

bind rxfifo_trig rxfifo_trig_chk #(.DEPTH(DEPTH), .TRIG_L3(TRIG_L3)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_push     (rx_push),
  .host_pop    (host_pop),
  .ctl_wr      (ctl_wr),
  .afc_en      (afc_en),
  .level       (level),
  .data_ready  (data_ready),
  .overrun     (overrun),
  .fifo_err    (fifo_err),
  .trig_hit    (trig_hit),
  .timeout     (timeout),
  .rts_ok      (rts_ok),
  .fifo_mode_q (fifo_mode_q)
);

// File: tb/tb_rxfifo_trig.sv
module tb_rxfifo_trig;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_push, rx_perr, rx_ferr, rx_brk, host_pop, ovr_clr, ctl_wr, afc_en, char_tick;
  logic [7:0] rx_byte, ctl_data, head_byte, level;
  logic       head_perr, head_ferr, head_brk, data_ready, overrun, fifo_err, trig_hit, timeout, rts_ok;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxfifo_trig dut (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_byte(rx_byte), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk), .host_pop(host_pop), .ovr_clr(ovr_clr),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data), .afc_en(afc_en), .char_tick(char_tick),
    .head_byte(head_byte), .head_perr(head_perr), .head_ferr(head_ferr), .head_brk(head_brk),
    .level(level), .data_ready(data_ready), .overrun(overrun), .fifo_err(fifo_err),
    .trig_hit(trig_hit), .timeout(timeout), .rts_ok(rts_ok)
  );

  // {threshold code, fill count, expected trig_hit, expected rts_ok}
  localparam logic [11:0] VEC [8] = '{
    {2'b00, 8'd0,   1'b0, 1'b1},
    {2'b00, 8'd1,   1'b1, 1'b0},
    {2'b01, 8'd15,  1'b0, 1'b1},
    {2'b01, 8'd16,  1'b1, 1'b0},
    {2'b10, 8'd63,  1'b0, 1'b1},
    {2'b10, 8'd64,  1'b1, 1'b0},
    {2'b11, 8'd111, 1'b0, 1'b1},
    {2'b11, 8'd112, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] d, logic p, logic f, logic b);
    rx_push = 1'b1; rx_byte = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    step();
    rx_push = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic pop();
    host_pop = 1'b1;
    step();
    host_pop = 1'b0;
  endtask

  task automatic ctl(logic [7:0] v);
    ctl_wr = 1'b1; ctl_data = v;
    step();
    ctl_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_push = 0; rx_byte = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    host_pop = 0; ovr_clr = 0; ctl_wr = 0; ctl_data = 0; afc_en = 0; char_tick = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R9 reset state
    check("R9 level", level, 0);
    check("R9 ready", data_ready, 0);
    check("R9 overrun", overrun, 0);
    check("R9 err", fifo_err, 0);
    check("R9 timeout", timeout, 0);
    check("R9 rts", rts_ok, 1);

    // R1 / R5 threshold table with flow control on
    afc_en = 1'b1;
    foreach (VEC[i]) begin
      ctl({VEC[i][11:10], 4'b0000, 2'b11});
      for (int k = 0; k < int'(VEC[i][9:2]); k++) push(8'(k), 0, 0, 0);
      check("R1 level", level, {24'd0, VEC[i][9:2]});
      check("R1 trig_hit", trig_hit, VEC[i][1]);
      check("R5 rts_ok", rts_ok, VEC[i][0]);
    end
    // R5 reassert after dropping below threshold 112
    pop();
    check("R5 reassert", rts_ok, 1);
    check("R1 below", trig_hit, 0);
    afc_en = 1'b0;
    push(8'hAA, 0, 0, 0);
    check("R5 afc off", rts_ok, 1);

    // R4 empty via bit 1
    ctl(8'b0000_0011);
    check("R4 flushed", level, 0);
    check("R4 ready", data_ready, 0);

    // R10 pop on empty
    pop();
    check("R10 level", level, 0);
    push(8'h5C, 0, 0, 0);
    check("R10 after", level, 1);
    check("R10 head", head_byte, 8'h5C);

    // R2 / R7 ordering and error marks
    ctl(8'b0000_0011);
    push(8'h10, 0, 0, 0);
    push(8'h20, 1, 0, 0);
    push(8'h30, 0, 0, 1);
    check("R2 level", level, 3);
    check("R7 err set", fifo_err, 1);
    check("R2 head0", head_byte, 8'h10);
    pop();
    check("R2 head1", head_byte, 8'h20);
    check("R2 perr", head_perr, 1);
    pop();
    check("R2 head2", head_byte, 8'h30);
    check("R2 brk", head_brk, 1);
    check("R7 err brk", fifo_err, 1);
    pop();
    check("R7 err clear", fifo_err, 0);
    push(8'h40, 0, 1, 0);
    check("R2 ferr", head_ferr, 1);
    ctl(8'b0000_0011);
    check("R4 err cleared", fifo_err, 0);

    // R3 overrun at 128 entries
    for (int k = 0; k < 128; k++) push(8'(k + 1), 0, 0, 0);
    check("R3 full", level, 128);
    check("R3 no ovr yet", overrun, 0);
    push(8'hEE, 0, 0, 0);
    check("R3 level kept", level, 128);
    check("R3 overrun", overrun, 1);
    check("R3 head kept", head_byte, 8'h01);
    ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
    check("R3 cleared", overrun, 0);
    for (int k = 0; k < 128; k++) begin
      if (head_byte !== 8'(k + 1)) check("R2 drain order", head_byte, 8'(k + 1));
      pop();
    end
    check("R3 drained", level, 0);
    checks++;

    // R8 timeout at threshold 16
    ctl(8'b0100_0011);
    push(8'h01, 0, 0, 0); push(8'h02, 0, 0, 0); push(8'h03, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin char_tick = 1; step(); char_tick = 0; end
    check("R8 not yet", timeout, 0);
    char_tick = 1; step(); char_tick = 0;
    check("R8 timeout", timeout, 1);
    pop();
    check("R8 cleared by pop", timeout, 0);
    check("R8 level", level, 2);

    // R6 single holding register (mode change also empties: R4)
    ctl(8'b0000_0000);
    check("R4 mode change empties", level, 0);
    push(8'h11, 0, 0, 0);
    check("R6 trig 1", trig_hit, 1);
    push(8'h22, 0, 0, 0);
    check("R6 single level", level, 1);
    check("R6 head", head_byte, 8'h11);
    check("R6 overrun", overrun, 1);
    char_tick = 1; repeat (5) step(); char_tick = 0;
    check("R8 no timeout single", timeout, 0);

    finish_run();
  end
endmodule